// File: doc/BRIEF.md
# Numerically Controlled Oscillator with Writable Phase

This block is a 32-bit counter peripheral that sits beside a processor. While it is in oscillator mode it adds an increment register to a phase accumulator on every system clock. One output pin, chosen by a field of the control word, is driven from the top bit of that accumulator through a register. The processor reaches the block through a small write bus with three registers: control, increment and phase. The current phase value can always be read back.

The phase register can be written at any time, even while accumulation runs, and a write wins over that cycle's addition. This lets the same hardware serve three purposes. With a non-zero increment it runs freely as a square-wave source. With a zero increment, software shifts the phase one bit per write and produces a serial data stream on the pin. With an increment of one, a negative preload of -N produces a single high pulse exactly N clocks long. When the mode field holds any code other than oscillator mode, the counter is disabled: the pin is low and the phase freezes. This is also how a running accumulator is kept from creating a stray edge when it wraps.

Top module: `nco_phase_counter`

## Requirements
- R1: After reset the control, increment and phase registers are zero, `bus_rdata` reads 0 and every bit of `pins_o` is 0.
- R2: When control bits 30..26 equal 5'b00100 (oscillator mode), the phase becomes phase + increment (modulo 2^32) on every clock that carries no phase write, with no prescaling.
- R3: The pin output is registered. After each clock edge, `pins_o[s]` equals bit 31 of the phase as it stood before that edge, when the mode sampled at that edge was oscillator mode. Here s is control bits 5..0. Every other bit of `pins_o` is 0, and if s >= NUM_PINS no bit is driven.
- R4: A write to address 2 loads `bus_wdata` into the phase at that clock edge and takes priority over the addition. Accumulation then continues from the loaded value.
- R5: With an increment of 0 in oscillator mode, the phase never changes by itself. Each write of the phase shifted left by one places the next bit on the pin one clock after the write.
- R6: With an increment of 1 in oscillator mode, writing the phase with the two's-complement value -N (N >= 1) makes the selected pin high for exactly N consecutive clocks, after which it goes low.
- R7: When control bits 30..26 hold any value other than 5'b00100, `pins_o` is 0 and the phase holds its value except for bus writes. This includes a phase just below 0x80000000 with an increment of 1, where no rising edge appears.
- R8: Address 0 writes the control word, address 1 the increment and address 2 the phase. A write to address 3 changes nothing. `bus_rdata` always returns the current phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 control, 1 increment, 2 phase, 3 none |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Current phase value |
| pins_o | output | NUM_PINS | Registered pin outputs, at most one high |

## Verification
A corrupted phase shows on `bus_rdata` at the negative edge right after the faulty clock edge, because the read port is the accumulator itself. One cycle later it shows on the selected pin whenever bit 31 is affected. A wrong pin select or wrong mode decode shows on `pins_o` one clock after the control write, as a wrong bit, two bits at once, or a pin that should be low but is high. Pulse-width and wrap errors take N clocks to appear, so the bench counts high cycles over a window longer than the pulse.

// File: rtl/nco_pkg.sv
package nco_pkg;

  localparam int WORD_W     = 32;
  localparam int MODE_W     = 5;
  localparam int PIN_SEL_W  = 6;
  localparam int MODE_LSB   = 26;

  typedef logic [WORD_W-1:0]    word_t;
  typedef logic [MODE_W-1:0]    mode_t;
  typedef logic [PIN_SEL_W-1:0] pin_sel_t;

  localparam mode_t MODE_OFF = 5'b00000;
  localparam mode_t MODE_NCO = 5'b00100;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_FREQ  = 2'd1,
    REG_PHASE = 2'd2,
    REG_NONE  = 2'd3
  } reg_addr_e;

  function automatic mode_t ctrl_mode(input word_t w);
    return w[MODE_LSB +: MODE_W];
  endfunction

  function automatic pin_sel_t ctrl_pin(input word_t w);
    return w[PIN_SEL_W-1:0];
  endfunction

  function automatic word_t phase_step(input word_t phase, input word_t incr);
    return phase + incr;
  endfunction

endpackage

// File: rtl/nco_cfg_regs.sv
module nco_cfg_regs
  import nco_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_ctrl,
  input  logic     wr_freq,
  input  mode_t    mode_in,
  input  pin_sel_t sel_in,
  input  word_t    freq_in,
  output logic     nco_active,
  output pin_sel_t pin_sel,
  output word_t    freq_q
);

  mode_t    mode_q;
  pin_sel_t sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
      sel_q  <= '0;
    end else if (wr_ctrl) begin
      mode_q <= mode_in;
      sel_q  <= sel_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       freq_q <= '0;
    else if (wr_freq) freq_q <= freq_in;
  end

  assign nco_active = (mode_q == MODE_NCO);
  assign pin_sel    = sel_q;

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc
  import nco_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_en,
  input  word_t load_val,
  input  logic  acc_en,
  input  word_t incr,
  output word_t phase_q
);

  word_t phase_d;

  always_comb begin
    if (load_en)     phase_d = load_val;
    else if (acc_en) phase_d = phase_step(phase_q, incr);
    else             phase_d = phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

endmodule

// File: rtl/nco_pin_drive.sv
module nco_pin_drive
  import nco_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                level,
  input  pin_sel_t            sel,
  output logic [NUM_PINS-1:0] pins_q
);

  logic drive_hi;
  assign drive_hi = enable && level;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pins_q[i] <= 1'b0;
      else        pins_q[i] <= drive_hi && (sel == PIN_SEL_W'(i));
    end
  end

endmodule

// File: rtl/nco_phase_counter.sv
module nco_phase_counter
  import nco_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic [1:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [NUM_PINS-1:0] pins_o
);

  localparam int MAX_PINS = 1 << PIN_SEL_W;

  if (NUM_PINS < 1 || NUM_PINS > MAX_PINS) begin : g_bad_pins
    $error("NUM_PINS out of range");
  end

  logic     wr_ctrl, wr_freq, wr_phase;
  logic     nco_active;
  pin_sel_t pin_sel;
  word_t    freq_q;
  word_t    phase_q;

  assign wr_ctrl  = bus_we && (bus_addr == REG_CTRL);
  assign wr_freq  = bus_we && (bus_addr == REG_FREQ);
  assign wr_phase = bus_we && (bus_addr == REG_PHASE);

  nco_cfg_regs u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ctrl    (wr_ctrl),
    .wr_freq    (wr_freq),
    .mode_in    (ctrl_mode(bus_wdata)),
    .sel_in     (ctrl_pin(bus_wdata)),
    .freq_in    (bus_wdata),
    .nco_active (nco_active),
    .pin_sel    (pin_sel),
    .freq_q     (freq_q)
  );

  nco_phase_acc u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (wr_phase),
    .load_val (bus_wdata),
    .acc_en   (nco_active),
    .incr     (freq_q),
    .phase_q  (phase_q)
  );

  nco_pin_drive #(.NUM_PINS(NUM_PINS)) u_pins (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (nco_active),
    .level  (phase_q[WORD_W-1]),
    .sel    (pin_sel),
    .pins_q (pins_o)
  );

  assign bus_rdata = phase_q;

endmodule

// File: rtl/nco_phase_counter_chk.sv
module nco_phase_counter_chk #(
  parameter int NUM_PINS = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_we,
  input logic [1:0]          bus_addr,
  input logic [31:0]         bus_wdata,
  input logic [31:0]         bus_rdata,
  input logic [NUM_PINS-1:0] pins_o,
  input logic                nco_active,
  input logic [5:0]          pin_sel,
  input logic [31:0]         freq_q
);

  logic phase_wr;
  assign phase_wr = bus_we && (bus_addr == 2'd2);

  // R2
  acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nco_active && !phase_wr) |=> bus_rdata == $past(bus_rdata + freq_q));

  // R4
  phase_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_wr |=> bus_rdata == $past(bus_wdata));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nco_active && !phase_wr) |=> $stable(bus_rdata));

  // R7
  idle_pin_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nco_active |=> pins_o == '0);

  // R3
  pin_one_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pins_o));

  // R3
  pin_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nco_active && bus_rdata[31]) |=> pins_o == (NUM_PINS'(1) << $past(pin_sel)));

  // R3
  pin_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rdata[31] |=> pins_o == '0);

endmodule

bind nco_phase_counter nco_phase_counter_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .pins_o     (pins_o),
  .nco_active (nco_active),
  .pin_sel    (pin_sel),
  .freq_q     (freq_q)
);

// File: tb/nco_phase_counter_test.sv
`timescale 1ns/1ps
module nco_phase_counter_test;

  localparam int NP = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_we = 1'b0;
  logic [1:0]    bus_addr = 2'd0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pins_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [4:0]    m_mode = '0;
  logic [5:0]    m_sel = '0;
  logic [31:0]   m_freq = '0;
  logic [31:0]   m_phase = '0;
  logic [NP-1:0] m_pins = '0;

  always #5 clk = ~clk;

  nco_phase_counter #(.NUM_PINS(NP)) uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pins_o(pins_o)
  );

  function automatic logic [31:0] ctrl_word(input logic [4:0] mode, input logic [5:0] sel);
    return {1'b0, mode, 20'd0, sel};
  endfunction

  function automatic logic [NP-1:0] want_pins(input logic [4:0] mode, input logic [5:0] sel,
                                              input logic [31:0] ph);
    logic [NP-1:0] r = '0;
    if (mode == 5'b00100 && ph[31] && int'(sel) < NP) r[sel] = 1'b1;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input logic we, input logic [1:0] a, input logic [31:0] d, input string tag);
    logic [NP-1:0] np;
    logic [31:0]   nph;
    bus_we = we; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    np  = want_pins(m_mode, m_sel, m_phase);
    nph = m_phase;
    if (we && a == 2'd2)          nph = d;
    else if (m_mode == 5'b00100)  nph = m_phase + m_freq;
    if (we && a == 2'd0) begin m_mode = d[30:26]; m_sel = d[5:0]; end
    if (we && a == 2'd1) m_freq = d;
    m_phase = nph;
    m_pins  = np;
    @(negedge clk);
    bus_we = 1'b0;
    chk({tag, " phase"}, 64'(bus_rdata), 64'(m_phase));
    chk({tag, " pins"},  64'(pins_o),    64'(m_pins));
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, 32'd0, tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] sv;
    int hi;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rdata", 64'(bus_rdata), 64'd0);
    chk("R1 pins", 64'(pins_o), 64'd0);
    rst_n = 1'b1;
    idle(3, "R1");

    // R2 free run, pin 3
    step(1, 2'd1, 32'h1000_0000, "R8");
    step(1, 2'd0, ctrl_word(5'b00100, 6'd3), "R2");
    idle(40, "R2");

    // R4 write priority while running
    step(1, 2'd1, 32'd5, "R4");
    step(1, 2'd2, 32'd100, "R4");
    chk("R4 loaded", 64'(bus_rdata), 64'd100);
    step(0, 2'd0, 32'd0, "R4");
    chk("R4 resumes", 64'(bus_rdata), 64'd105);

    // R5 serial shift with zero increment
    step(1, 2'd1, 32'd0, "R5");
    sv = 32'hB000_0000;
    step(1, 2'd2, sv, "R5");
    for (int b = 0; b < 6; b++) begin
      step(0, 2'd0, 32'd0, "R5");
      chk("R5 serial bit", 64'(pins_o[3]), 64'(sv[31-b]));
      step(1, 2'd2, bus_rdata << 1, "R5");
    end

    // R6 pulse width N=7
    step(1, 2'd1, 32'd1, "R6");
    step(1, 2'd2, -32'sd7, "R6");
    hi = 0;
    for (int i = 0; i < 20; i++) begin
      step(0, 2'd0, 32'd0, "R6");
      if (pins_o[3]) hi++;
    end
    chk("R6 pulse width", 64'(hi), 64'd7);
    step(1, 2'd2, -32'sd1, "R6");
    hi = 0;
    for (int i = 0; i < 6; i++) begin
      step(0, 2'd0, 32'd0, "R6");
      if (pins_o[3]) hi++;
    end
    chk("R6 pulse width one", 64'(hi), 64'd1);

    // R3 wrap edge while enabled, then R7 suppression when disabled
    step(1, 2'd2, 32'h7FFF_FFFD, "R3");
    idle(5, "R3");
    chk("R3 wrap rising", 64'(pins_o[3]), 64'd1);
    step(1, 2'd0, ctrl_word(5'b00000, 6'd3), "R7");
    step(1, 2'd2, 32'h7FFF_FFFD, "R7");
    idle(6, "R7");
    chk("R7 held phase", 64'(bus_rdata), 64'h7FFF_FFFD);
    chk("R7 pin low", 64'(pins_o), 64'd0);
    step(1, 2'd0, ctrl_word(5'b00101, 6'd3), "R7");
    idle(6, "R7");
    chk("R7 other mode held", 64'(bus_rdata), 64'h7FFF_FFFD);

    // R3 out-of-range select drives nothing
    step(1, 2'd2, 32'hC000_0000, "R3");
    step(1, 2'd1, 32'd0, "R3");
    step(1, 2'd0, ctrl_word(5'b00100, 6'd40), "R3");
    idle(3, "R3");
    chk("R3 sel out of range", 64'(pins_o), 64'd0);
    step(1, 2'd0, ctrl_word(5'b00100, 6'd31), "R3");
    idle(2, "R3");
    chk("R3 top pin", 64'(pins_o), 64'h8000_0000);

    // R8 address 3 ignored
    step(1, 2'd3, 32'hFFFF_FFFF, "R8");
    idle(2, "R8");
    chk("R8 addr3 phase", 64'(bus_rdata), 64'hC000_0000);
    chk("R8 addr3 pins", 64'(pins_o), 64'h8000_0000);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom % 10);
      case (r)
        0: step(1, 2'd0, ctrl_word(($urandom % 4 != 0) ? 5'b00100 : 5'($urandom),
                                   6'($urandom % 40)), "R2");
        1: step(1, 2'd1, ($urandom % 3 == 0) ? 32'd0 : $urandom, "R2");
        2: step(1, 2'd2, $urandom, "R4");
        3: step(1, 2'd3, $urandom, "R8");
        default: step(0, 2'd0, 32'd0, "R3");
      endcase
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule